// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the host-facing side of a simple serial port. It sits on a byte-wide register bus that decodes six address bits. It holds two mode bytes, a transmit holding byte and an interrupt mask. It turns a packed command byte into receiver, transmitter and pointer actions, and it drives one level-sensitive interrupt line. The serializer, the baud generator and the receive FIFO are separate blocks. This controller passes a held byte to the serializer with a one-cycle strobe. It reads, pops and flushes the external receive FIFO through a few strobes and flags.

Both mode bytes share one address. A pointer selects which one is accessed. The pointer moves to the second byte after any write to that address, and a command returns it to the first. One command write can reset a path, enable or disable the transmitter, and enable or disable the receiver, in that fixed order of evaluation. The receive interrupt fires either when the FIFO is non-empty or when it is full, depending on one mode bit.

Top module: `uart_regctl`

## Requirements
- R1: After a synchronous active-low reset, both mode bytes and the mask are 0. The status reads 0x08, the interrupt status reads 0x00, and the transmitter and receiver are disabled. The mode pointer selects the first mode byte.
- R2: Offset 0x00 reads and writes the mode byte chosen by the pointer. A write moves the pointer to the second byte. Command misc value 1 moves it back to the first byte.
- R3: Status (offset 0x04 read) has bit0 = FIFO not empty, bit1 = FIFO full, bit2 = transmitter enabled (ready), bit3 = transmit holding byte empty. Bits 7:4 read 0.
- R4: The command byte (offset 0x08 write) carries misc = bits[6:4], transmit = bits[3:2] and receive = bits[1:0], applied in that order. Misc values 0, 4, 6 and 7 change nothing.
- R5: Writing offset 0x0C clears the empty flag and stores the byte. Whenever the transmitter is enabled and the flag is clear, the byte is sent and the flag is set again. The send is a `tx_valid` pulse one cycle after the write, with `tx_data` holding the byte. Transmit field 1 enables and field 2 disables. Misc 3 disables the transmitter and sets the empty flag.
- R6: A read of offset 0x0C returns the FIFO head and pulses `rxq_pop` in the same cycle if the FIFO is non-empty. If it is empty, the read returns 0 and there is no pop. Misc 2 pulses `rxq_flush` and disables the receiver. Receive field 1 and field 2 set and clear `rx_enable`.
- R7: Interrupt status (offset 0x14 read) has bit0 = transmitter ready, bit1 = receive interrupt, bit2 = break change, bit7 = 0. A write to 0x14 sets the mask. `irq` is high exactly when status AND mask is nonzero.
- R8: Writes to 0x04, 0x10, 0x18, 0x1C and to unmapped offsets change nothing. Reads of 0x10 and of unmapped offsets return 0. 0x18 and 0x1C return the two fixed divider bytes.
- R9: A `rx_break` pulse sets interrupt status bit2. Misc 5 clears it. If both happen in the same cycle, the set wins.
- R10: Value 3 in the transmit or receive field is ignored.
- R11: When mode byte 0 bit6 is 1, the receive interrupt follows FIFO full. When it is 0, the receive interrupt follows FIFO not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | One-cycle send strobe to serializer |
| tx_data | output | 8 | Byte being sent |
| rxq_head | input | 8 | Receive FIFO head byte |
| rxq_nonempty | input | 1 | Receive FIFO holds at least one byte |
| rxq_full | input | 1 | Receive FIFO is full |
| rxq_pop | output | 1 | Pop the FIFO head |
| rxq_flush | output | 1 | Empty the FIFO |
| rx_enable | output | 1 | Receiver enabled |
| rx_break | input | 1 | Break condition seen on the line |

## Verification
The bench targets these cases:
- A command that resets the transmitter and enables it in the same byte. If the order of evaluation were wrong, the stale held byte would be sent again.
- A byte written while the transmitter is disabled and then released by an enable command. A design that got this wrong would lose the byte or send it twice.
- A read of the data register on an empty FIFO. A wrong design would pop anyway or return the stale head.
- Switching the receive interrupt source between not-empty and full. A wrong design would raise the interrupt early or late.
- The mode pointer after a write and after its reset command. A wrong design would corrupt the other mode byte.
- Reserved field values and a break set colliding with a break clear. Both must leave the state as the requirements say.

// File: rtl/uart_rc_pkg.sv
// Shared constants and command types for the UART register controller.
// Assumes a byte-wide data path and six decoded address bits.
package uart_rc_pkg;

    localparam logic [5:0] OFS_MODE   = 6'h00;
    localparam logic [5:0] OFS_STAT   = 6'h04;
    localparam logic [5:0] OFS_CMD    = 6'h08;
    localparam logic [5:0] OFS_DATA   = 6'h0C;
    localparam logic [5:0] OFS_AUX    = 6'h10;
    localparam logic [5:0] OFS_INT    = 6'h14;
    localparam logic [5:0] OFS_DIV_HI = 6'h18;
    localparam logic [5:0] OFS_DIV_LO = 6'h1C;

    // Mode byte 0 bit that selects the receive interrupt source
    localparam int RXSEL_BIT = 6;

    typedef enum logic [2:0] {
        MISC_NOP       = 3'd0,
        MISC_PTR_RST   = 3'd1,
        MISC_RX_RST    = 3'd2,
        MISC_TX_RST    = 3'd3,
        MISC_ERR_RST   = 3'd4,
        MISC_BRK_CLR   = 3'd5,
        MISC_BRK_START = 3'd6,
        MISC_BRK_STOP  = 3'd7
    } misc_cmd_e;

    typedef enum logic [1:0] {
        PATH_NOP  = 2'd0,
        PATH_ON   = 2'd1,
        PATH_OFF  = 2'd2,
        PATH_RSVD = 2'd3
    } path_cmd_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

endpackage

// File: rtl/uart_rc_cmd_decode.sv
// Splits a command byte into action strobes.
// Assumes the strobe is valid only when cmd_wr is high; reserved codes give no action.
module uart_rc_cmd_decode
    import uart_rc_pkg::*;
(
    input  logic       cmd_wr,
    input  logic [6:0] cmd_byte,
    output cmd_act_t   act
);
    misc_cmd_e misc_f;
    path_cmd_e tx_f;
    path_cmd_e rx_f;

    assign misc_f = misc_cmd_e'(cmd_byte[6:4]);
    assign tx_f   = path_cmd_e'(cmd_byte[3:2]);
    assign rx_f   = path_cmd_e'(cmd_byte[1:0]);

    // Translate the three fields into independent strobes
    always_comb begin
        act = '0;
        if (cmd_wr) begin
            unique case (misc_f)
                MISC_PTR_RST: act.ptr_rst = 1'b1;
                MISC_RX_RST:  act.rx_rst  = 1'b1;
                MISC_TX_RST:  act.tx_rst  = 1'b1;
                MISC_BRK_CLR: act.brk_clr = 1'b1;
                default:      ;
            endcase
            unique case (tx_f)
                PATH_ON:  act.tx_on  = 1'b1;
                PATH_OFF: act.tx_off = 1'b1;
                default:  ;
            endcase
            unique case (rx_f)
                PATH_ON:  act.rx_on  = 1'b1;
                PATH_OFF: act.rx_off = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rc_tx.sv
// Transmit holding byte, enable and empty flag, with a send strobe.
// Assumes the downstream serializer always accepts a byte; a command and
// a data write never arrive in the same cycle.
module uart_rc_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_rst,
    input  logic              tx_on,
    input  logic              tx_off,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_data,
    output logic              tx_en,
    output logic              tx_emp,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);
    logic [DATA_W-1:0] buf_q, buf_n, snd_data;
    logic              en_n, emp_n, snd;

    // Apply reset, enable/disable, then a buffer write, in that order
    always_comb begin
        en_n     = tx_en;
        emp_n    = tx_emp;
        buf_n    = buf_q;
        snd      = 1'b0;
        snd_data = buf_q;
        if (tx_rst) begin
            en_n  = 1'b0;
            emp_n = 1'b1;
        end
        if (tx_on) begin
            en_n = 1'b1;
            if (!emp_n) begin
                snd      = 1'b1;
                snd_data = buf_q;
                emp_n    = 1'b1;
            end
        end else if (tx_off) begin
            en_n = 1'b0;
        end
        if (buf_wr) begin
            buf_n = buf_data;
            emp_n = 1'b0;
            if (en_n) begin
                snd      = 1'b1;
                snd_data = buf_data;
                emp_n    = 1'b1;
            end
        end
    end

    // Register the transmit state and the send strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            tx_emp   <= 1'b1;
            buf_q    <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_en    <= en_n;
            tx_emp   <= emp_n;
            buf_q    <= buf_n;
            tx_valid <= snd;
            if (snd) tx_data <= snd_data;
        end
    end
endmodule

// File: rtl/uart_rc_rx.sv
// Receiver enable and strobes toward the external receive FIFO.
// Assumes the FIFO empties on the cycle after a flush strobe.
module uart_rc_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_rst,
    input  logic              rx_on,
    input  logic              rx_off,
    input  logic              data_rd,
    input  logic [DATA_W-1:0] q_head,
    input  logic              q_nonempty,
    output logic [DATA_W-1:0] rd_byte,
    output logic              q_pop,
    output logic              q_flush,
    output logic              rx_en
);
    // Track the receiver enable, reset first then the receive field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
        end else if (rx_on) begin
            rx_en <= 1'b1;
        end else if (rx_off || rx_rst) begin
            rx_en <= 1'b0;
        end
    end

    // Pop only a present byte; an empty FIFO reads as zero
    always_comb begin
        q_pop   = data_rd && q_nonempty;
        rd_byte = q_nonempty ? q_head : '0;
        q_flush = rx_rst;
    end
endmodule

// File: rtl/uart_rc_irq.sv
// Interrupt status composition, break-change flag and the masked interrupt line.
// Assumes the mask is registered elsewhere and the FIFO flags are live.
module uart_rc_irq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_set,
    input  logic              brk_clr,
    input  logic              tx_rdy,
    input  logic              q_nonempty,
    input  logic              q_full,
    input  logic              sel_full,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] isr,
    output logic              irq
);
    logic brk_q;
    logic rx_int;

    // Break-change flag; a new break wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
        end else if (brk_set) begin
            brk_q <= 1'b1;
        end else if (brk_clr) begin
            brk_q <= 1'b0;
        end
    end

    // Assemble the status byte and the masked line
    always_comb begin
        rx_int = sel_full ? q_full : q_nonempty;
        isr    = '0;
        isr[0] = tx_rdy;
        isr[1] = rx_int;
        isr[2] = brk_q;
        irq    = |(isr & mask);
    end
endmodule

// File: rtl/uart_regctl.sv
// Register file and control of a simple UART: mode bytes, status, command,
// transmit holding byte, interrupt mask and the interrupt line.
// Assumes one bus access per cycle and a combinational read path.
module uart_regctl
    import uart_rc_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter int          DATA_W   = 8,
    parameter int          NUM_MODE = 2,
    parameter logic [7:0]  DIV_HI   = 8'h00,
    parameter logic [7:0]  DIV_LO   = 8'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic [DATA_W-1:0] rxq_head,
    input  logic              rxq_nonempty,
    input  logic              rxq_full,
    output logic              rxq_pop,
    output logic              rxq_flush,
    output logic              rx_enable,
    input  logic              rx_break
);
    localparam int PTR_W = (NUM_MODE > 1) ? $clog2(NUM_MODE) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_MODE - 1);

    logic wr_mode, wr_cmd, wr_data, wr_mask, rd_data;
    cmd_act_t act;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] mode_v [NUM_MODE];
    logic [DATA_W-1:0] imr_q;
    logic [DATA_W-1:0] isr_v, stat_v, rx_byte;
    logic              tx_en, tx_emp;

    // Address decode of the accesses that have an effect
    always_comb begin
        wr_mode = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
        wr_cmd  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
        wr_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
        wr_mask = bus_wr && (bus_addr == ADDR_W'(OFS_INT));
        rd_data = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));
    end

    uart_rc_cmd_decode u_cmd (
        .cmd_wr   (wr_cmd),
        .cmd_byte (bus_wdata[6:0]),
        .act      (act)
    );

    // Mode bytes, one register per slot
    for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
        logic [DATA_W-1:0] q;
        // Store the bus byte when the pointer selects this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_mode && (ptr_q == PTR_W'(g))) begin
                q <= bus_wdata;
            end
        end
        assign mode_v[g] = q;
    end

    // Mode pointer: advances after a write, saturates, returns on command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (act.ptr_rst) begin
            ptr_q <= '0;
        end else if (wr_mode) begin
            ptr_q <= (ptr_q == PTR_LAST) ? PTR_LAST : ptr_q + 1'b1;
        end
    end

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q <= '0;
        end else if (wr_mask) begin
            imr_q <= bus_wdata;
        end
    end

    uart_rc_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_rst   (act.tx_rst),
        .tx_on    (act.tx_on),
        .tx_off   (act.tx_off),
        .buf_wr   (wr_data),
        .buf_data (bus_wdata),
        .tx_en    (tx_en),
        .tx_emp   (tx_emp),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    uart_rc_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_rst     (act.rx_rst),
        .rx_on      (act.rx_on),
        .rx_off     (act.rx_off),
        .data_rd    (rd_data),
        .q_head     (rxq_head),
        .q_nonempty (rxq_nonempty),
        .rd_byte    (rx_byte),
        .q_pop      (rxq_pop),
        .q_flush    (rxq_flush),
        .rx_en      (rx_enable)
    );

    uart_rc_irq #(.DATA_W(DATA_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_set    (rx_break),
        .brk_clr    (act.brk_clr),
        .tx_rdy     (tx_en),
        .q_nonempty (rxq_nonempty),
        .q_full     (rxq_full),
        .sel_full   (mode_v[0][RXSEL_BIT]),
        .mask       (imr_q),
        .isr        (isr_v),
        .irq        (irq)
    );

    // Status byte from the live flags
    always_comb begin
        stat_v    = '0;
        stat_v[0] = rxq_nonempty;
        stat_v[1] = rxq_full;
        stat_v[2] = tx_en;
        stat_v[3] = tx_emp;
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                ADDR_W'(OFS_MODE):   bus_rdata = mode_v[ptr_q];
                ADDR_W'(OFS_STAT):   bus_rdata = stat_v;
                ADDR_W'(OFS_DATA):   bus_rdata = rx_byte;
                ADDR_W'(OFS_INT):    bus_rdata = isr_v;
                ADDR_W'(OFS_DIV_HI): bus_rdata = DATA_W'(DIV_HI);
                ADDR_W'(OFS_DIV_LO): bus_rdata = DATA_W'(DIV_LO);
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_regctl_chk.sv
// Property checker for the UART register controller, attached by bind.
module uart_regctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic [7:0] imr_q,
    input logic       tx_valid,
    input logic       tx_en,
    input logic       tx_emp,
    input logic       rxq_pop,
    input logic       rxq_nonempty,
    input logic       wr_mode,
    input logic       ptr_q
);
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (imr_q == 8'h00) |-> !irq);

    assert_send_leaves_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_emp);

    assert_send_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_en);

    assert_pop_only_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |-> rxq_nonempty);

    assert_mode_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> ptr_q);
endmodule

bind uart_regctl uart_regctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .imr_q        (imr_q),
    .tx_valid     (tx_valid),
    .tx_en        (tx_en),
    .tx_emp       (tx_emp),
    .rxq_pop      (rxq_pop),
    .rxq_nonempty (rxq_nonempty),
    .wr_mode      (wr_mode),
    .ptr_q        (ptr_q[0])
);

// File: tb/tb_uart_regctl.sv
`timescale 1ns/1ps
module tb_uart_regctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, rx_break = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, tx_data;
    logic       irq, tx_valid, rxq_pop, rxq_flush, rx_enable;
    logic [7:0] rxq_head = '0;
    logic       rxq_nonempty = 1'b0, rxq_full = 1'b0;

    always #2.5 clk = ~clk;

    uart_regctl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data),
        .rxq_head(rxq_head), .rxq_nonempty(rxq_nonempty), .rxq_full(rxq_full),
        .rxq_pop(rxq_pop), .rxq_flush(rxq_flush), .rx_enable(rx_enable),
        .rx_break(rx_break)
    );

    // Behavioural reference state
    int        n_chk = 0, n_bad = 0;
    string     tag = "R1";
    byte       fifo[$];
    int        m_mode[2];
    int        m_ptr, m_imr;
    bit        m_txen, m_txemp, m_rxen, m_brk;
    int        m_txbuf;

    task automatic chk(string t, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode[0] = 0; m_mode[1] = 0; m_ptr = 0; m_imr = 0;
        m_txen = 0; m_txemp = 1; m_rxen = 0; m_brk = 0; m_txbuf = 0;
        fifo.delete();
    endtask

    task automatic drive_fifo();
        rxq_nonempty = (fifo.size() > 0);
        rxq_full     = (fifo.size() == 4);
        rxq_head     = (fifo.size() > 0) ? fifo[0] : 8'h00;
    endtask

    // One bus cycle with comparison before and after the clock edge
    task automatic step(bit wr, bit rd, int a, int d, bit push, int pd, bit brk);
        int ne, fu, st, isr, rdx, rxi, exp_irq;
        bit pop, flush, snd;
        int snd_d;
        int misc, txf, rxf;
        bit old_rxen;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a[5:0]; bus_wdata = d[7:0]; rx_break = brk;
        #1;
        ne  = (fifo.size() > 0);
        fu  = (fifo.size() == 4);
        st  = ne | (fu << 1) | (int'(m_txen) << 2) | (int'(m_txemp) << 3);
        rxi = m_mode[0][6] ? fu : ne;
        isr = int'(m_txen) | (rxi << 1) | (int'(m_brk) << 2);
        exp_irq = ((isr & m_imr) != 0);
        pop = rd && (a == 8'h0C) && ne;
        misc = (d >> 4) & 7; txf = (d >> 2) & 3; rxf = d & 3;
        flush = wr && (a == 8'h08) && (misc == 2);
        case (a)
            8'h00: rdx = m_mode[m_ptr];
            8'h04: rdx = st;
            8'h0C: rdx = ne ? int'(fifo[0]) & 8'hFF : 0;
            8'h14: rdx = isr;
            8'h18: rdx = 8'h00;
            8'h1C: rdx = 8'h1A;
            default: rdx = 0;
        endcase
        if (rd) chk(tag, $sformatf("read @%0h", a), bus_rdata, rdx);
        chk("R7", "irq", irq, exp_irq);
        chk("R6", "rxq_pop", rxq_pop, pop);
        chk("R6", "rxq_flush", rxq_flush, flush);
        chk("R6", "rx_enable", rx_enable, m_rxen);
        old_rxen = m_rxen;
        snd = 0; snd_d = 0;
        if (wr) begin
            case (a)
                8'h00: begin m_mode[m_ptr] = d & 8'hFF; m_ptr = 1; end
                8'h08: begin
                    if (misc == 1) m_ptr = 0;
                    if (misc == 2) m_rxen = 0;
                    if (misc == 3) begin m_txen = 0; m_txemp = 1; end
                    if (misc == 5) m_brk = 0;
                    if (txf == 1) begin
                        m_txen = 1;
                        if (!m_txemp) begin snd = 1; snd_d = m_txbuf; m_txemp = 1; end
                    end else if (txf == 2) m_txen = 0;
                    if (rxf == 1) m_rxen = 1;
                    else if (rxf == 2) m_rxen = 0;
                end
                8'h0C: begin
                    m_txbuf = d & 8'hFF; m_txemp = 0;
                    if (m_txen) begin snd = 1; snd_d = m_txbuf; m_txemp = 1; end
                end
                8'h14: m_imr = d & 8'hFF;
                default: ;
            endcase
        end
        if (brk) m_brk = 1;
        @(posedge clk);
        #1;
        if (pop) void'(fifo.pop_front());
        if (flush) fifo.delete();
        if (push && old_rxen && fifo.size() < 4) fifo.push_back(pd[7:0]);
        drive_fifo();
        chk("R5", "tx_valid", tx_valid, snd);
        if (snd) chk("R5", "tx_data", tx_data, snd_d);
    endtask

    task automatic wr_reg(int a, int d); step(1, 0, a, d, 0, 0, 0); endtask
    task automatic rd_reg(int a);        step(0, 1, a, 0, 0, 0, 0); endtask
    task automatic push(int b);          step(0, 0, 0, 0, 1, b, 0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lcg;
        model_reset();
        drive_fifo();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        tag = "R1";
        rd_reg(8'h04); rd_reg(8'h14); rd_reg(8'h00);

        // R2 mode pointer
        tag = "R2";
        wr_reg(8'h00, 8'h11); wr_reg(8'h00, 8'h22); rd_reg(8'h00);
        wr_reg(8'h08, 8'h10); rd_reg(8'h00);
        wr_reg(8'h00, 8'h05); rd_reg(8'h00);
        wr_reg(8'h08, 8'h10); rd_reg(8'h00);

        // R5 transmit holding byte
        tag = "R5";
        wr_reg(8'h0C, 8'hA5); rd_reg(8'h04);
        wr_reg(8'h08, 8'h04); rd_reg(8'h04);
        wr_reg(8'h0C, 8'h3C); wr_reg(8'h0C, 8'hC3); rd_reg(8'h04);
        wr_reg(8'h08, 8'h08); wr_reg(8'h0C, 8'h77); rd_reg(8'h04);
        wr_reg(8'h08, 8'h30); rd_reg(8'h04);
        // R4 reset then enable in one byte: nothing stale is sent
        tag = "R4";
        wr_reg(8'h0C, 8'h99); wr_reg(8'h08, 8'h34); rd_reg(8'h04);
        wr_reg(8'h08, 8'h40); wr_reg(8'h08, 8'h60); wr_reg(8'h08, 8'h70); rd_reg(8'h04);

        // R6 receive path
        tag = "R6";
        rd_reg(8'h0C);
        wr_reg(8'h08, 8'h01);
        push(8'h41); push(8'h42); push(8'h43);
        rd_reg(8'h04); rd_reg(8'h0C); rd_reg(8'h0C);
        push(8'h44); push(8'h45); push(8'h46);
        tag = "R3";
        rd_reg(8'h04);
        tag = "R6";
        wr_reg(8'h08, 8'h20); rd_reg(8'h04); rd_reg(8'h0C);

        // R7 masked interrupt
        tag = "R7";
        wr_reg(8'h14, 8'h01); rd_reg(8'h14);
        wr_reg(8'h08, 8'h01); push(8'h10); wr_reg(8'h14, 8'h02); rd_reg(8'h14);

        // R11 receive interrupt source select
        tag = "R11";
        wr_reg(8'h08, 8'h10); wr_reg(8'h00, 8'h40); rd_reg(8'h14);
        push(8'h11); push(8'h12); push(8'h13); rd_reg(8'h14);
        rd_reg(8'h0C); rd_reg(8'h14);

        // R9 break change
        tag = "R9";
        wr_reg(8'h14, 8'h04);
        step(0, 0, 0, 0, 0, 0, 1); rd_reg(8'h14);
        wr_reg(8'h08, 8'h50); rd_reg(8'h14);
        step(1, 0, 8'h08, 8'h50, 0, 0, 1); rd_reg(8'h14);
        wr_reg(8'h08, 8'h50);

        // R10 reserved field values
        tag = "R10";
        wr_reg(8'h08, 8'h0F); rd_reg(8'h04);
        wr_reg(8'h08, 8'h04); wr_reg(8'h08, 8'h0F); rd_reg(8'h04);

        // R8 ignored writes and unmapped reads
        tag = "R8";
        wr_reg(8'h04, 8'hFF); wr_reg(8'h10, 8'hFF); wr_reg(8'h18, 8'hFF);
        wr_reg(8'h1C, 8'hFF); wr_reg(8'h24, 8'hFF); wr_reg(8'h02, 8'hFF);
        rd_reg(8'h04); rd_reg(8'h10); rd_reg(8'h24); rd_reg(8'h02);
        rd_reg(8'h18); rd_reg(8'h1C); rd_reg(8'h14); rd_reg(8'h00);

        // R3 mixed traffic against the model
        tag = "R3";
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            int op, v;
            lcg = lcg * 1103515245 + 12345;
            op = (lcg >>> 16) & 15;
            v  = (lcg >>> 8) & 8'hFF;
            case (op)
                0, 1:    wr_reg(8'h0C, v);
                2, 3:    wr_reg(8'h08, v & 8'h7F);
                4, 5, 6: push(v);
                7:       wr_reg(8'h14, v);
                8:       step(0, 0, 0, 0, 0, 0, 1);
                9:       wr_reg(8'h00, v);
                10, 11:  rd_reg(8'h0C);
                12:      rd_reg(8'h04);
                13:      rd_reg(8'h14);
                default: rd_reg(8'h00);
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule